// File: doc/BRIEF.md
# Memory BIST signature controller

This block walks a nonvolatile memory array from a programmed first address to a programmed last address, both inclusive. It reads one 16-bit word (two bytes) at each even byte address. Each returned word updates two independent 16-bit signature registers. One register absorbs only the data bytes. The other absorbs only the per-byte parity bits. Software compares the final pair against a known-good value to detect stuck or corrupted cells.

The byte address is laid out as `{upper, cs, lower}`. The chip-select field sits between the upper page bits and the lower in-page bits, so consecutive pages land on different devices. Two sweep modes exist:

- In whole-space mode the address counts straight through and so crosses devices as it goes.
- In single-device mode the chip-select field stays frozen at the first address's value, and only the concatenation of upper and lower bits counts.

The control pins are plain: a one-cycle start strobe, configuration levels, and busy, done and signature outputs. The memory port has no back-pressure. The read latency is fixed at one cycle, so a read issued in one cycle must have its data on `mem_data`/`mem_par` in the next cycle. For that reason no valid/ready pair is needed on that side.

Top module: `msig_bist_ctrl`

## Requirements
- R1: Only even addresses are read. Bit 0 of the first and last addresses is treated as zero, `mem_addr[0]` is always 0 while `mem_rd` is high, and the address advances by 2 per read. The last address is read too.
- R2: The address is `{upper (UPPER_W bits), cs (CS_W bits), lower (LOWER_W bits)}`, with the lower field holding bit 0. In whole-space mode (`cfg_dev_only`=0) the full address increments by 2, so the lower field carries into cs and cs carries into upper. The sweep ends once the full address equals the last address.
- R3: In single-device mode (`cfg_dev_only`=1) the cs field of every read equals the cs field of the first address. Only `{upper, lower}` advances by 2, and the sweep ends once `{upper, lower}` equals that of the last address.
- R4: A one-cycle high on `start_wr` while idle launches a sweep and captures the configuration. The request needs no clearing. A `start_wr` while `busy` is high has no effect on the running sweep or its result.
- R5: Exactly one read per address, one per cycle, with `mem_rd` high and `mem_addr` valid in the same cycle. The word on `mem_data`/`mem_par` in the following cycle is the one compressed.
- R6: The data signature is a MISR with polynomial x^16+x^12+x^5+1: next = {s[14:0],0} ^ (s[15] ? 16'h1021 : 0) ^ data. It is cleared at launch and updated once per word.
- R7: The parity signature uses the same MISR rule, fed with `mem_par` (bit 0 for the low byte, bit 1 for the high byte) zero-extended to 16 bits.
- R8: `signature[15:0]` is the data signature and `signature[31:16]` is the parity signature. Both are zero after reset and in the cycle after launch.
- R9: `busy` is high from the cycle after launch until the last word is compressed. `done` is low after reset and after launch. It rises with the last compression and stays high until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_first | input | ADDR_W | First byte address of the sweep |
| cfg_last | input | ADDR_W | Last byte address of the sweep |
| cfg_dev_only | input | 1 | 1: single-device sweep with cs frozen |
| start_wr | input | 1 | Start request strobe |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sticky completion flag |
| signature | output | 32 | {parity signature, data signature} |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | ADDR_W | Read byte address |
| mem_data | input | 16 | Read data, one cycle after the strobe |
| mem_par | input | 2 | Per-byte parity, one cycle after the strobe |

## Verification
A faulty address counter shows up on `mem_addr` in the cycle it steps wrong. Examples are a cs bit that moves in single-device mode, an odd address, or a missed carry. The bench's memory model compares every strobed address against the sequence it expects. A wrong MISR tap or a skipped update stays hidden inside the register until `done` rises. After that it shows as a miscompare of the whole 32-bit word. An off-by-one end condition shows both as an extra or missing read and as a changed signature.

// File: rtl/msig_pkg.sv
package msig_pkg;
  localparam int SIG_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;

  // one MISR step, x^16 + x^12 + x^5 + 1, Galois form
  function automatic logic [SIG_W-1:0] misr_next(input logic [SIG_W-1:0] s,
                                                input logic [SIG_W-1:0] d);
    return {s[SIG_W-2:0], 1'b0} ^ (s[SIG_W-1] ? SIG_POLY : '0) ^ d;
  endfunction
endpackage

// File: rtl/msig_addr_seq.sv
module msig_addr_seq #(
  parameter int UPPER_W = 8,
  parameter int CS_W    = 1,
  parameter int LOWER_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic                              step,
  input  logic                              dev_only,
  input  logic [UPPER_W+CS_W+LOWER_W-1:0]   first,
  input  logic [UPPER_W+CS_W+LOWER_W-1:0]   last,
  output logic [UPPER_W+CS_W+LOWER_W-1:0]   addr,
  output logic                              at_last
);
  localparam int ADDR_W = UPPER_W + CS_W + LOWER_W;
  localparam int UL_W   = UPPER_W + LOWER_W;

  logic [ADDR_W-1:0] cur, stop_q, nxt;
  logic              mode_q;
  logic              unused_lsb;

  assign unused_lsb = first[0] ^ last[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      stop_q <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      cur    <= {first[ADDR_W-1:1], 1'b0};
      stop_q <= {last[ADDR_W-1:1], 1'b0};
      mode_q <= dev_only;
    end else if (step) begin
      cur <= nxt;
    end
  end

  generate
    if (CS_W == 0) begin : g_single
      logic unused_mode;
      assign unused_mode = mode_q;
      assign nxt     = cur + ADDR_W'(2);
      assign at_last = (cur == stop_q);
    end else begin : g_multi
      logic [UL_W-1:0] ul_cur, ul_stop, ul_nxt;
      assign ul_cur  = {cur[ADDR_W-1 -: UPPER_W], cur[LOWER_W-1:0]};
      assign ul_stop = {stop_q[ADDR_W-1 -: UPPER_W], stop_q[LOWER_W-1:0]};
      assign ul_nxt  = ul_cur + UL_W'(2);

      always_comb begin
        if (mode_q) begin
          nxt     = {ul_nxt[UL_W-1 -: UPPER_W], cur[LOWER_W +: CS_W], ul_nxt[LOWER_W-1:0]};
          at_last = (ul_cur == ul_stop);
        end else begin
          nxt     = cur + ADDR_W'(2);
          at_last = (cur == stop_q);
        end
      end

      // R3: the device field never moves during a single-device sweep
      p_cs_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_q) |=> $stable(cur[LOWER_W +: CS_W]));
    end
  endgenerate

  assign addr = cur;
endmodule

// File: rtl/msig_misr.sv
module msig_misr
  import msig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [SIG_W-1:0] din,
  output logic [SIG_W-1:0] sig
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sig <= '0;
    else if (clear)  sig <= '0;
    else if (en)     sig <= misr_next(sig, din);
  end
endmodule

// File: rtl/msig_bist_ctrl.sv
module msig_bist_ctrl
  import msig_pkg::*;
#(
  parameter int UPPER_W = 8,
  parameter int CS_W    = 1,
  parameter int LOWER_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [UPPER_W+CS_W+LOWER_W-1:0]  cfg_first,
  input  logic [UPPER_W+CS_W+LOWER_W-1:0]  cfg_last,
  input  logic                             cfg_dev_only,
  input  logic                             start_wr,
  output logic                             busy,
  output logic                             done,
  output logic [2*SIG_W-1:0]               signature,
  output logic                             mem_rd,
  output logic [UPPER_W+CS_W+LOWER_W-1:0]  mem_addr,
  input  logic [SIG_W-1:0]                 mem_data,
  input  logic [1:0]                       mem_par
);
  localparam int ADDR_W = UPPER_W + CS_W + LOWER_W;
  localparam int NBYTES = SIG_W / 8;

  logic issuing, pend, pend_last, done_q;
  logic launch, step, at_last;
  logic [SIG_W-1:0] data_sig, par_sig, par_ext;

  assign busy   = issuing | pend;
  assign launch = start_wr & ~busy;
  assign step   = issuing & ~at_last;

  msig_addr_seq #(.UPPER_W(UPPER_W), .CS_W(CS_W), .LOWER_W(LOWER_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(launch), .step(step),
    .dev_only(cfg_dev_only), .first(cfg_first), .last(cfg_last),
    .addr(mem_addr), .at_last(at_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing   <= 1'b0;
      pend      <= 1'b0;
      pend_last <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (launch)                 issuing <= 1'b1;
      else if (issuing && at_last) issuing <= 1'b0;
      pend      <= issuing;
      pend_last <= issuing & at_last;
      if (launch)                 done_q <= 1'b0;
      else if (pend && pend_last) done_q <= 1'b1;
    end
  end

  assign mem_rd  = issuing;
  assign done    = done_q;
  assign par_ext = {{(SIG_W-NBYTES){1'b0}}, mem_par};

  msig_misr u_data_sig (
    .clk(clk), .rst_n(rst_n), .clear(launch), .en(pend),
    .din(mem_data), .sig(data_sig)
  );
  msig_misr u_par_sig (
    .clk(clk), .rst_n(rst_n), .clear(launch), .en(pend),
    .din(par_ext), .sig(par_sig)
  );

  assign signature = {par_sig, data_sig};

  // R1: never an odd byte address on the read port
  p_even_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[0] == 1'b0));
  // R9: completion and activity are exclusive
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: launch leaves both signatures at zero
  p_sig_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (signature == '0));
  // R6: no compression without a returning word
  p_sig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !launch) |=> $stable(signature));
  // R4: a start while busy does not end or restart the sweep early
  p_busy_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing && !at_last && start_wr) |=> mem_rd);
endmodule

// File: tb/tb_msig_bist_ctrl.sv
module tb_msig_bist_ctrl;
  localparam int CLK_P = 10;
  localparam int UW = 3, CW = 1, LW = 3;
  localparam int AW = UW + CW + LW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cfg_first = '0, cfg_last = '0;
  logic cfg_dev_only = 1'b0, start_wr = 1'b0;
  logic busy, done, mem_rd;
  logic [31:0] signature;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_data = '0;
  logic [1:0]  mem_par = '0;

  int n_chk = 0, n_bad = 0;
  int seen = 0, addr_bad = 0, exp_n = 0;
  logic [AW-1:0] exp_a [0:127];

  always #(CLK_P/2) clk = ~clk;

  msig_bist_ctrl #(.UPPER_W(UW), .CS_W(CW), .LOWER_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_first(cfg_first), .cfg_last(cfg_last),
    .cfg_dev_only(cfg_dev_only), .start_wr(start_wr), .busy(busy), .done(done),
    .signature(signature), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_par(mem_par)
  );

  function automatic logic [15:0] dfun(input logic [AW-1:0] a);
    logic [7:0] b = 8'(a);
    return {b * 8'd29 + 8'd7, b ^ 8'h5C};
  endfunction
  function automatic logic [1:0] pfun(input logic [AW-1:0] a);
    logic [15:0] d = dfun(a);
    return {^d[15:8] ^ a[2], ^d[7:0]};
  endfunction
  function automatic logic [15:0] mstep(input logic [15:0] s, input logic [15:0] d);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0) ^ d;
  endfunction
  function automatic logic [UW+LW-1:0] ul_of(input logic [AW-1:0] a);
    return {a[AW-1 -: UW], a[LW-1:0]};
  endfunction

  // behavioural memory: one-cycle latency, checks every strobed address
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= dfun(mem_addr);
      mem_par  <= pfun(mem_addr);
      if (seen >= exp_n || mem_addr != exp_a[seen]) addr_bad <= addr_bad + 1;
      seen <= seen + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] f, input logic [AW-1:0] l, input bit dev, input bit poke);
    logic [AW-1:0] a, stp;
    logic [15:0] ds, ps;
    logic [UW+LW-1:0] u;
    int wait_c;
    a = {f[AW-1:1], 1'b0}; stp = {l[AW-1:1], 1'b0};
    exp_n = 0; ds = '0; ps = '0;
    forever begin
      exp_a[exp_n] = a; exp_n++;
      ds = mstep(ds, dfun(a));
      ps = mstep(ps, {14'b0, pfun(a)});
      if (dev ? (ul_of(a) == ul_of(stp)) : (a == stp)) break;
      if (exp_n >= 128) break;
      if (dev) begin
        u = ul_of(a) + (UW+LW)'(2);
        a = {u[UW+LW-1 -: UW], a[LW +: CW], u[LW-1:0]};
      end else a = a + AW'(2);
    end
    @(negedge clk);
    seen = 0; addr_bad = 0;
    cfg_first = f; cfg_last = l; cfg_dev_only = dev; start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R9 launch", {30'b0, busy, done}, 32'h2);
    check(signature === 32'h0, "R8 cleared at launch", signature, 32'h0);
    if (poke) begin
      repeat (3) @(negedge clk);
      cfg_first = ~f; cfg_last = ~f; cfg_dev_only = ~dev; start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
    end
    wait_c = 0;
    while (done !== 1'b1 && wait_c < 400) begin @(negedge clk); wait_c++; end
    check(done === 1'b1 && busy === 1'b0, "R9 completion", {30'b0, busy, done}, 32'h1);
    check(seen == exp_n, "R5 read count", seen, exp_n);
    check(addr_bad == 0, dev ? "R3 address sequence" : "R2 address sequence", addr_bad, 0);
    check(signature === {ps, ds}, poke ? "R4 start while busy ignored" : "R6 R7 signatures",
          signature, {ps, ds});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_rd === 1'b0, "R9 reset state",
          {29'b0, busy, done, mem_rd}, 0);
    check(signature === 32'h0, "R8 reset signature", signature, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(7'h00, 7'h7E, 1'b0, 1'b0);        // R2 whole space
    run(7'h00, 7'h76, 1'b1, 1'b0);        // R3 device 0
    run(7'h08, 7'h7E, 1'b1, 1'b0);        // R3 device 1
    run(7'h06, 7'h0A, 1'b0, 1'b0);        // R2 carry lower -> cs
    run(7'h0E, 7'h1A, 1'b1, 1'b0);        // R3 carry lower -> upper, cs held
    run(7'h24, 7'h24, 1'b0, 1'b0);        // R1 single word, stop inclusive
    run(7'h13, 7'h17, 1'b0, 1'b0);        // R1 odd bounds forced even
    run(7'h00, 7'h7E, 1'b0, 1'b1);        // R4 start while busy
    repeat (10) @(negedge clk);
    check(done === 1'b1, "R9 done sticky", {31'b0, done}, 1);
    for (int s = 0; s < 128; s += 10) begin
      run(AW'(s), 7'h7F, 1'b0, 1'b0);
      run(AW'(s), {3'b111, s[3], 3'b111}, 1'b1, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule